// File: doc/BRIEF.md
# Sector Protection and Write-Enable Gate

This block sits between a serial-flash command decoder and the array sequencer. For each decoded program, erase or protection command it decides whether the command may run. It keeps a write-enable latch and one protect bit for each of sixteen 64 KB sectors.

The decoder presents a one-cycle `cmd_valid` strobe with a command code and a 24-bit address. With the strobe it flags whether the frame was cut short, meaning an incomplete address or a chip-select release off a byte boundary. Within one cycle the block answers with either a `go_o` pulse, carrying an aligned start address for the sequencer, or an `abort_o` pulse. An accepted program or erase marks the block busy until the sequencer returns `seq_done`. That pulse also drops the latch.

Protect, unprotect and the global status write change the protect bits at once. A low level on `wp_n` locks the protect bits against every such change. A query command returns a byte view of one sector's protect bit.

Top module: `sgate`

## Requirements
- R1: After reset, `wel_o` and `busy_o` are 0, `prot_o` is FFFFh (all sectors protected), `go_o` and `abort_o` are 0 and `prot_byte_o` is 00h.
- R2: Code 1 (write enable) sets `wel_o` and code 2 (write disable) clears it, one cycle after the strobe. If either is flagged truncated, `wel_o` keeps its value and neither `go_o` nor `abort_o` pulses.
- R3: Codes 3 (program), 4/5/6 (erase 4 KB/32 KB/64 KB), 7 (chip erase), 8 (protect sector), 9 (unprotect sector) and 10 (global status write) pulse `abort_o` instead of `go_o` when `wel_o` is 0.
- R4: A program or block erase whose sector, address bits 19..16, has its protect bit set is aborted, and `wel_o` is cleared.
- R5: On `go_o`, `go_addr_o` has bits 23..20 at zero. Program passes bits 19..0 unchanged. The 4 KB, 32 KB and 64 KB erases also clear bits 11..0, 14..0 and 15..0 respectively. `go_kind_o` repeats the accepted code.
- R6: Chip erase is aborted, with `wel_o` cleared, if any protect bit is set. When accepted, it reports `go_addr_o` = 0.
- R7: A truncated command of codes 3 to 10 is aborted, and `wel_o` is cleared.
- R8: An accepted program or erase sets `busy_o`, and `wel_o` stays 1. While `busy_o` is 1, strobes are ignored. `seq_done` while busy clears both `busy_o` and `wel_o`.
- R9: An accepted protect (8) or unprotect (9) sets or clears only the bit of the addressed sector, and clears `wel_o`.
- R10: An accepted global status write (10) sets all sixteen protect bits when `gbl_protect` is 1 and clears them all when it is 0, and clears `wel_o`.
- R11: While `wp_n` is 0, codes 8, 9 and 10 are aborted with `wel_o` cleared, and `prot_o` does not change.
- R12: Code 11 (protection query) loads `prot_byte_o` with FFh if the addressed sector is protected and 00h otherwise, one cycle after the strobe.
- R13: `go_o` and `abort_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_kind | input | 4 | Command code (see requirements) |
| cmd_addr | input | 24 | Command address |
| cmd_trunc | input | 1 | Frame ended early or off a byte boundary |
| gbl_protect | input | 1 | Global status write data: 1 protect all, 0 unprotect all |
| seq_done | input | 1 | Array cycle finished pulse |
| wp_n | input | 1 | Hardware lock of the protect bits when low |
| go_o | output | 1 | Command granted pulse |
| abort_o | output | 1 | Command refused pulse |
| go_kind_o | output | 4 | Code of the granted command |
| go_addr_o | output | 24 | Aligned start address for the sequencer |
| wel_o | output | 1 | Write-enable latch |
| busy_o | output | 1 | Program or erase in progress |
| prot_o | output | 16 | Per-sector protect bits |
| prot_byte_o | output | 8 | Result of the last protection query |

## Verification
Several rules are checked by assertions on every cycle: grants never coincide with refusals, and a grant always follows a set latch. A granted program or erase never targets a sector that was protected, and a granted chip erase never happens while any bit was set. Every refusal leaves the latch cleared, the protect bits hold still while the lock pin is low, and a busy block answers nothing. Only the bench's scenarios can show the exact values: the aligned addresses of each erase size, which single bit a protect or unprotect touches, the query bytes, and that truncated latch commands leave the latch alone.

// File: rtl/sgate_pkg.sv
// Shared command codes, protect-bit operations and the verdict record
// passed from the decision logic to the state registers.
package sgate_pkg;

    typedef enum logic [3:0] {
        K_NONE   = 4'd0,
        K_WREN   = 4'd1,
        K_WRDI   = 4'd2,
        K_PROG   = 4'd3,
        K_ER_S   = 4'd4,
        K_ER_M   = 4'd5,
        K_ER_L   = 4'd6,
        K_CHIP   = 4'd7,
        K_PROT   = 4'd8,
        K_UNPROT = 4'd9,
        K_GSET   = 4'd10,
        K_QUERY  = 4'd11
    } kind_e;

    typedef enum logic [2:0] {
        P_KEEP   = 3'd0,
        P_SET1   = 3'd1,
        P_CLR1   = 3'd2,
        P_SETALL = 3'd3,
        P_CLRALL = 3'd4
    } pop_e;

    typedef struct packed {
        logic go;
        logic abort;
        logic wel_set;
        logic wel_clr;
        logic busy_set;
        logic query;
        pop_e pop;
    } verdict_t;

endpackage

// File: rtl/sgate_judge.sv
// Combinational permission decision for one command strobe.
// Assumes: the strobe lasts one cycle; the protect vector and latch are the
// registered values of the current cycle.
module sgate_judge
    import sgate_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int ARRAY_BITS = 20,
    parameter int SECT_W     = 4,
    parameter int ER_S_BITS  = 12,
    parameter int ER_M_BITS  = 15,
    parameter int ER_L_BITS  = 16
) (
    input  logic                    valid,
    input  kind_e                   kind,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    trunc,
    input  logic                    gbl,
    input  logic                    wel,
    input  logic                    busy,
    input  logic                    wp_n,
    input  logic [(1<<SECT_W)-1:0]  prot,
    output verdict_t                v,
    output logic [ADDR_W-1:0]       go_addr
);
    localparam int SECT_LSB = ARRAY_BITS - SECT_W;
    localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] MASK_S = ~((ONE << ER_S_BITS) - ONE);
    localparam logic [ADDR_W-1:0] MASK_M = ~((ONE << ER_M_BITS) - ONE);
    localparam logic [ADDR_W-1:0] MASK_L = ~((ONE << ER_L_BITS) - ONE);

    logic              sect_hit;
    logic [ADDR_W-1:0] arr_addr;

    assign sect_hit = prot[addr[SECT_LSB +: SECT_W]];
    assign arr_addr = {{(ADDR_W-ARRAY_BITS){1'b0}}, addr[ARRAY_BITS-1:0]};

    // Decide grant, refusal and side effects for the current strobe.
    always_comb begin
        v     = '0;
        v.pop = P_KEEP;
        if (valid && !busy) begin
            unique case (kind)
                K_WREN:  v.wel_set = !trunc;
                K_WRDI:  v.wel_clr = !trunc;
                K_PROG, K_ER_S, K_ER_M, K_ER_L: begin
                    if (trunc || !wel || sect_hit) begin
                        v.abort   = 1'b1;
                        v.wel_clr = 1'b1;
                    end else begin
                        v.go       = 1'b1;
                        v.busy_set = 1'b1;
                    end
                end
                K_CHIP: begin
                    if (trunc || !wel || (|prot)) begin
                        v.abort   = 1'b1;
                        v.wel_clr = 1'b1;
                    end else begin
                        v.go       = 1'b1;
                        v.busy_set = 1'b1;
                    end
                end
                K_PROT, K_UNPROT, K_GSET: begin
                    v.wel_clr = 1'b1;
                    if (trunc || !wel || !wp_n) begin
                        v.abort = 1'b1;
                    end else begin
                        v.go = 1'b1;
                        if (kind == K_PROT)        v.pop = P_SET1;
                        else if (kind == K_UNPROT) v.pop = P_CLR1;
                        else if (gbl)              v.pop = P_SETALL;
                        else                       v.pop = P_CLRALL;
                    end
                end
                K_QUERY: v.query = !trunc;
                default: v = v;
            endcase
        end
    end

    // Align the start address handed to the sequencer.
    always_comb begin
        unique case (kind)
            K_ER_S:  go_addr = arr_addr & MASK_S;
            K_ER_M:  go_addr = arr_addr & MASK_M;
            K_ER_L:  go_addr = arr_addr & MASK_L;
            K_CHIP:  go_addr = '0;
            default: go_addr = arr_addr;
        endcase
    end
endmodule

// File: rtl/sgate_wel.sv
// Write-enable latch and busy flag.
// Assumes: busy_set is only asserted while busy is low.
module sgate_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic wel_set,
    input  logic wel_clr,
    input  logic busy_set,
    input  logic done,
    output logic wel,
    output logic busy
);
    // Latch: cleared by a refusal, an instant grant or the end of a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                   wel <= 1'b0;
        else if (wel_clr || (done && busy)) wel <= 1'b0;
        else if (wel_set)             wel <= 1'b1;
    end

    // Busy: set on a granted array cycle, cleared on sequencer completion.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy <= 1'b0;
        else if (busy_set) busy <= 1'b1;
        else if (done)     busy <= 1'b0;
    end
endmodule

// File: rtl/sgate_prot.sv
// Per-sector protect register; one bit per sector, all set at reset.
// Assumes: idx is valid whenever pop names a single sector.
module sgate_prot
    import sgate_pkg::*;
#(
    parameter int SECT_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  pop_e                   pop,
    input  logic [SECT_W-1:0]      idx,
    output logic [(1<<SECT_W)-1:0] prot
);
    localparam int NSECT = 1 << SECT_W;

    for (genvar i = 0; i < NSECT; i++) begin : g_bit
        // Update one sector bit from a single or global operation.
        always_ff @(posedge clk) begin
            if (!rst_n) prot[i] <= 1'b1;
            else begin
                unique case (pop)
                    P_SETALL: prot[i] <= 1'b1;
                    P_CLRALL: prot[i] <= 1'b0;
                    P_SET1:   if (idx == SECT_W'(i)) prot[i] <= 1'b1;
                    P_CLR1:   if (idx == SECT_W'(i)) prot[i] <= 1'b0;
                    default:  prot[i] <= prot[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/sgate.sv
// Top: permission gate for program, erase and protection commands.
// Assumes: one decoded command per cmd_valid pulse; seq_done pulses once
// per granted array cycle. All outputs are registered.
module sgate
    import sgate_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int ARRAY_BITS = 20,
    parameter int SECT_W     = 4,
    parameter int ER_S_BITS  = 12,
    parameter int ER_M_BITS  = 15,
    parameter int ER_L_BITS  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [3:0]              cmd_kind,
    input  logic [ADDR_W-1:0]       cmd_addr,
    input  logic                    cmd_trunc,
    input  logic                    gbl_protect,
    input  logic                    seq_done,
    input  logic                    wp_n,
    output logic                    go_o,
    output logic                    abort_o,
    output logic [3:0]              go_kind_o,
    output logic [ADDR_W-1:0]       go_addr_o,
    output logic                    wel_o,
    output logic                    busy_o,
    output logic [(1<<SECT_W)-1:0]  prot_o,
    output logic [7:0]              prot_byte_o
);
    localparam int SECT_LSB = ARRAY_BITS - SECT_W;

    kind_e             kind;
    verdict_t          vd;
    logic [ADDR_W-1:0] aligned;

    assign kind = kind_e'(cmd_kind);

    sgate_judge #(
        .ADDR_W(ADDR_W), .ARRAY_BITS(ARRAY_BITS), .SECT_W(SECT_W),
        .ER_S_BITS(ER_S_BITS), .ER_M_BITS(ER_M_BITS), .ER_L_BITS(ER_L_BITS)
    ) u_judge (
        .valid   (cmd_valid),
        .kind    (kind),
        .addr    (cmd_addr),
        .trunc   (cmd_trunc),
        .gbl     (gbl_protect),
        .wel     (wel_o),
        .busy    (busy_o),
        .wp_n    (wp_n),
        .prot    (prot_o),
        .v       (vd),
        .go_addr (aligned)
    );

    sgate_wel u_wel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wel_set  (vd.wel_set),
        .wel_clr  (vd.wel_clr),
        .busy_set (vd.busy_set),
        .done     (seq_done),
        .wel      (wel_o),
        .busy     (busy_o)
    );

    sgate_prot #(.SECT_W(SECT_W)) u_prot (
        .clk   (clk),
        .rst_n (rst_n),
        .pop   (vd.pop),
        .idx   (cmd_addr[SECT_LSB +: SECT_W]),
        .prot  (prot_o)
    );

    // Register the grant/refusal pulses and the grant details.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_o      <= 1'b0;
            abort_o   <= 1'b0;
            go_kind_o <= 4'd0;
            go_addr_o <= '0;
        end else begin
            go_o    <= vd.go;
            abort_o <= vd.abort;
            if (vd.go) begin
                go_kind_o <= cmd_kind;
                go_addr_o <= aligned;
            end
        end
    end

    // Capture the byte view of the queried sector's protect bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        prot_byte_o <= 8'h00;
        else if (vd.query) prot_byte_o <= {8{prot_o[cmd_addr[SECT_LSB +: SECT_W]]}};
    end
endmodule

// File: rtl/sgate_chk.sv
// Property checker for sgate, attached by bind below.
module sgate_chk
    import sgate_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int ARRAY_BITS = 20,
    parameter int SECT_W     = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_valid,
    input logic [3:0]              cmd_kind,
    input logic [ADDR_W-1:0]       cmd_addr,
    input logic                    cmd_trunc,
    input logic                    gbl_protect,
    input logic                    seq_done,
    input logic                    wp_n,
    input logic                    go_o,
    input logic                    abort_o,
    input logic [3:0]              go_kind_o,
    input logic [ADDR_W-1:0]       go_addr_o,
    input logic                    wel_o,
    input logic                    busy_o,
    input logic [(1<<SECT_W)-1:0]  prot_o,
    input logic [7:0]              prot_byte_o
);
    localparam int SECT_LSB = ARRAY_BITS - SECT_W;

    logic [(1<<SECT_W)-1:0] prot_q;
    logic                   arr_go;

    // Previous-cycle copy of the protect bits.
    always_ff @(posedge clk) begin
        if (!rst_n) prot_q <= '1;
        else        prot_q <= prot_o;
    end

    assign arr_go = go_o && (go_kind_o inside {K_PROG, K_ER_S, K_ER_M, K_ER_L});

    AST_GO_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(go_o && abort_o)); // R13
    AST_GO_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> $past(wel_o)); // R3
    AST_ABORT_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !wel_o); // R7
    AST_SECTOR_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        arr_go |-> !prot_q[go_addr_o[SECT_LSB +: SECT_W]]); // R4
    AST_CHIP_ALL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (go_o && go_kind_o == K_CHIP) |-> (prot_q == '0 && go_addr_o == '0)); // R6
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_o) |-> (!go_o && !abort_o)); // R8
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seq_done && busy_o) |-> (!busy_o && !wel_o)); // R8
    AST_WP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wp_n) |-> $stable(prot_o)); // R11
endmodule

bind sgate sgate_chk #(.ADDR_W(ADDR_W), .ARRAY_BITS(ARRAY_BITS), .SECT_W(SECT_W)) u_chk (.*);

// File: tb/sim_sgate.sv
// Directed bench for sgate: one task per scenario.
module sim_sgate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_kind = 4'd0;
    logic [23:0] cmd_addr = 24'd0;
    logic        cmd_trunc = 1'b0;
    logic        gbl_protect = 1'b0;
    logic        seq_done = 1'b0;
    logic        wp_n = 1'b1;
    logic        go_o, abort_o, wel_o, busy_o;
    logic [3:0]  go_kind_o;
    logic [23:0] go_addr_o;
    logic [15:0] prot_o;
    logic [7:0]  prot_byte_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sgate u0 (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Present one strobe; on return the registered outputs are settled.
    task automatic issue(logic [3:0] k, logic [23:0] a, logic tr = 1'b0, logic g = 1'b0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = k; cmd_addr = a; cmd_trunc = tr; gbl_protect = g;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_trunc = 1'b0;
    endtask

    task automatic finish_cycle();
        @(negedge clk);
        seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 wel", wel_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 prot", prot_o, 16'hFFFF);
        chk("R1 pulses", {go_o, abort_o}, 0);
        chk("R1 query", prot_byte_o, 0);
    endtask

    task automatic t_latch();
        issue(1, 0);           chk("R2 set", wel_o, 1);
        issue(2, 0, 1'b1);     chk("R2 trunc disable", wel_o, 1);
        chk("R2 no pulse", {go_o, abort_o}, 0);
        issue(2, 0);           chk("R2 clear", wel_o, 0);
        issue(1, 0, 1'b1);     chk("R2 trunc enable", wel_o, 0);
    endtask

    task automatic t_no_latch();
        issue(9, 24'h030000);
        chk("R3 abort", {go_o, abort_o}, 2'b01);
        chk("R3 prot kept", prot_o, 16'hFFFF);
        issue(3, 24'h000010);
        chk("R3 program abort", {go_o, abort_o}, 2'b01);
    endtask

    task automatic t_global();
        issue(1, 0); issue(10, 0, 1'b0, 1'b0);
        chk("R10 go", go_o, 1);
        chk("R10 cleared", prot_o, 0);
        chk("R10 wel", wel_o, 0);
        issue(1, 0); issue(10, 0, 1'b0, 1'b1);
        chk("R10 all set", prot_o, 16'hFFFF);
        issue(1, 0); issue(10, 0, 1'b0, 1'b0);
        chk("R10 clear again", prot_o, 0);
    endtask

    task automatic t_sector();
        issue(1, 0); issue(8, 24'h05ABCD);
        chk("R9 one bit", prot_o, 16'h0020);
        chk("R9 wel", wel_o, 0);
        issue(11, 24'h050000); chk("R12 protected", prot_byte_o, 8'hFF);
        issue(11, 24'h04FFFF); chk("R12 open", prot_byte_o, 8'h00);
        issue(1, 0); issue(3, 24'h051234);
        chk("R4 program refused", {go_o, abort_o}, 2'b01);
        chk("R4 wel", wel_o, 0);
        issue(1, 0); issue(4, 24'h05FFFF);
        chk("R4 erase refused", abort_o, 1);
    endtask

    task automatic t_align();
        issue(1, 0); issue(4, 24'hF34567);
        chk("R5 4k go", go_o, 1);
        chk("R5 4k addr", go_addr_o, 24'h034000);
        chk("R5 kind", go_kind_o, 4);
        chk("R8 busy", busy_o, 1);
        chk("R8 wel held", wel_o, 1);
        @(negedge clk);
        chk("R13 pulse ends", go_o, 0);
        issue(2, 0);
        chk("R8 ignored", {wel_o, go_o, abort_o}, 3'b100);
        finish_cycle();
        chk("R8 done", {busy_o, wel_o}, 0);
        issue(1, 0); issue(5, 24'h03CDEF);
        chk("R5 32k addr", go_addr_o, 24'h038000);
        finish_cycle();
        issue(1, 0); issue(6, 24'h0ABCDE);
        chk("R5 64k addr", go_addr_o, 24'h0A0000);
        finish_cycle();
        issue(1, 0); issue(3, 24'h1ABCDE);
        chk("R5 program addr", go_addr_o, 24'h0ABCDE);
        finish_cycle();
    endtask

    task automatic t_chip();
        issue(1, 0); issue(8, 24'h070000);
        issue(1, 0); issue(7, 0);
        chk("R6 refused", {go_o, abort_o}, 2'b01);
        chk("R6 wel", wel_o, 0);
        issue(1, 0); issue(10, 0, 1'b0, 1'b0);
        issue(1, 0); issue(7, 24'h0F1234);
        chk("R6 go", go_o, 1);
        chk("R6 addr", go_addr_o, 0);
        finish_cycle();
    endtask

    task automatic t_trunc();
        issue(1, 0); issue(3, 24'h020000, 1'b1);
        chk("R7 abort", {go_o, abort_o}, 2'b01);
        chk("R7 wel", wel_o, 0);
        issue(11, 24'h020000, 1'b1);
        chk("R2 trunc query no change", prot_byte_o, 8'h00);
    endtask

    task automatic t_wp();
        wp_n = 1'b0;
        issue(1, 0); issue(8, 24'h010000);
        chk("R11 abort", abort_o, 1);
        chk("R11 prot kept", prot_o, 0);
        chk("R11 wel", wel_o, 0);
        issue(1, 0); issue(10, 0, 1'b0, 1'b1);
        chk("R11 global kept", prot_o, 0);
        wp_n = 1'b1;
        issue(1, 0); issue(8, 24'h010000);
        chk("R9 after unlock", prot_o, 16'h0002);
        issue(1, 0); issue(9, 24'h01FFFF);
        chk("R9 unprotect", prot_o, 0);
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_no_latch();
        t_global();
        t_sector();
        t_align();
        t_chip();
        t_trunc();
        t_wp();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule